// File: doc/BRIEF.md
# Wide-Word Bundle Dispatch Stage

This block is the dispatch stage of a statically scheduled wide-issue core. Each cycle it can take one wide instruction word made of several fixed-size operation slots and forward every slot, bit for bit, into a registered output lane. Each lane feeds one functional unit. Lane 0 goes to the first integer unit, lane 1 to the second integer unit, lane 2 to the memory unit and lane 3 to the floating-point unit.

The stage never compares one operation with another, either inside a word or across words. The compiler must space dependent operations apart, and it fills unused slots with empty encodings. The lane valid flag only tells a unit whether to act. The single way to stop the stage is a global freeze input, raised on a data-cache miss. The freeze holds every output register and drops the ready signal to the fetch side. No individual slot or word can be held back on its own.

Top module: `wide_word_dispatch`

## Requirements
- R1: When the freeze input is low, the contents of slot i of the presented word appear unchanged on output lane i one clock edge later. Lane contents load whether or not the word is valid.
- R2: Slot i occupies bits [32i+31:32i] of the input word. Lane 0 is the first integer unit, lane 1 the second integer unit, lane 2 the memory unit and lane 3 the floating-point unit.
- R3: A slot whose opcode field (bits [31:26] of the slot) is all zeros is empty. Its lane valid bit is low after the edge, even when the word is valid.
- R4: A word presented with its valid input low gives all lane valid bits low after the edge, whatever opcodes it carries.
- R5: While freeze is high at an edge, every lane valid bit and every lane's contents keep their previous values.
- R6: The ready output is the inverse of freeze, in the same cycle.
- R7: The first edge at which freeze is low again accepts the word presented in that cycle.
- R8: Consecutive valid words are dispatched on every edge with no hazard check. Words with identical or dependent operations never cause a stall, and ready stays high.
- R9: A synchronous active-high reset clears all lane valid bits and lane contents to zero.
- R10: Reset takes priority over freeze when both are high at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Global stall from a data-cache miss |
| word_valid | input | 1 | The presented word is real |
| word_in | input | 128 | Wide instruction word, four 32-bit slots |
| word_ready | output | 1 | Stage can accept a word this cycle |
| lane_valid | output | 4 | Per-lane start strobe for each functional unit |
| lane_op | output | 128 | Registered slot contents, lane i at bits [32i+31:32i] |

## Verification
Two functions can land on the same edge: a freeze and the arrival of a new valid word, and a freeze and a reset. The bench provokes the first by presenting changing non-empty words for several frozen cycles. It then checks that the lanes still show the word from before the freeze, and that the word present when freeze drops is the one taken. It provokes the second by raising reset and freeze together on the same cycle and expecting cleared lanes. A behavioural model judges every edge, and random stretches mix empty slots, idle words and freezes on top of these directed cases.

// File: rtl/ww_pkg.sv
package ww_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_SLOT_W = 32;
  localparam int unsigned DEF_OPC_W  = 6;

  typedef enum logic [1:0] {
    UNIT_INT_A = 2'd0,
    UNIT_INT_B = 2'd1,
    UNIT_MEM   = 2'd2,
    UNIT_FPU   = 2'd3
  } unit_e;
endpackage

// File: rtl/ww_empty_detect.sv
module ww_empty_detect #(
  parameter int unsigned SLOT_W = ww_pkg::DEF_SLOT_W,
  parameter int unsigned OPC_W  = ww_pkg::DEF_OPC_W
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              is_empty
);
  localparam int unsigned OPC_MSB = SLOT_W - 1;

  always_comb begin
    is_empty = (slot[OPC_MSB -: OPC_W] == '0);
  end
endmodule

// File: rtl/ww_lane.sv
module ww_lane #(
  parameter int unsigned SLOT_W = ww_pkg::DEF_SLOT_W,
  parameter int unsigned OPC_W  = ww_pkg::DEF_OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              word_valid,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              vld_q,
  output logic [SLOT_W-1:0] op_q
);
  logic empty;

  ww_empty_detect #(.SLOT_W(SLOT_W), .OPC_W(OPC_W)) u_empty (
    .slot     (slot_in),
    .is_empty (empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      op_q  <= '0;
    end else if (!freeze) begin
      vld_q <= word_valid && !empty;
      op_q  <= slot_in;
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> op_q == $past(slot_in));

  assert_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (!freeze && slot_in[SLOT_W-1 -: OPC_W] == '0) |=> !vld_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(op_q) && $stable(vld_q)));

  assert_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!vld_q && op_q == '0));
endmodule

// File: rtl/wide_word_dispatch.sv
module wide_word_dispatch #(
  parameter int unsigned LANES  = ww_pkg::DEF_LANES,
  parameter int unsigned SLOT_W = ww_pkg::DEF_SLOT_W,
  parameter int unsigned OPC_W  = ww_pkg::DEF_OPC_W,
  localparam int unsigned WORD_W = LANES * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_ready,
  output logic [LANES-1:0]  lane_valid,
  output logic [WORD_W-1:0] lane_op
);
  always_comb begin
    word_ready = !freeze;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ww_lane #(.SLOT_W(SLOT_W), .OPC_W(OPC_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .freeze     (freeze),
      .word_valid (word_valid),
      .slot_in    (word_in[g*SLOT_W +: SLOT_W]),
      .vld_q      (lane_valid[g]),
      .op_q       (lane_op[g*SLOT_W +: SLOT_W])
    );
  end

  assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !word_valid) |=> lane_valid == '0);

  assert_nostall_R8: assert property (@(posedge clk) disable iff (rst)
    (!freeze && word_valid) |=> $past(word_ready));

  assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(freeze) && !freeze) |=> lane_op == $past(word_in));
endmodule

// File: tb/wide_word_dispatch_bench.sv
module wide_word_dispatch_bench;
  localparam int N = 4;
  localparam int W = 32;
  localparam int WW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          freeze = 1'b0;
  logic          word_valid = 1'b0;
  logic [WW-1:0] word_in = '0;
  logic          word_ready;
  logic [N-1:0]  lane_valid;
  logic [WW-1:0] lane_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0]  m_vld = '0;
  logic [WW-1:0] m_op  = '0;

  always #10 clk = ~clk;

  wide_word_dispatch u_wide_word_dispatch (
    .clk(clk), .rst(rst), .freeze(freeze), .word_valid(word_valid),
    .word_in(word_in), .word_ready(word_ready),
    .lane_valid(lane_valid), .lane_op(lane_op)
  );

  function automatic logic [W-1:0] mk(input logic [5:0] opc, input logic [25:0] rest);
    return {opc, rest};
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_vld = '0;
      m_op  = '0;
    end else if (!freeze) begin
      for (int i = 0; i < N; i++) begin
        logic [W-1:0] s;
        s = word_in[i*W +: W];
        m_op[i*W +: W] = s;
        m_vld[i] = word_valid && (s[31:26] != 6'd0);
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic f,
                      input logic [WW-1:0] w, input string tag);
    @(negedge clk);
    rst = r; word_valid = v; freeze = f; word_in = w;
    #1;
    checks++;
    if (word_ready !== !f) begin
      fails++;
      $display("FAIL R6 ready: actual %b expected %b", word_ready, !f);
    end
    @(posedge clk);
    #1;
    model_edge();
    checks++;
    if (lane_valid !== m_vld || lane_op !== m_op) begin
      fails++;
      $display("FAIL %s: actual vld=%b op=%h expected vld=%b op=%h",
               tag, lane_valid, lane_op, m_vld, m_op);
    end
  endtask

  initial begin
    logic [WW-1:0] wa, wb, wc;
    // R9: reset state
    step(1'b1, 1'b0, 1'b0, '0, "R9 reset");
    step(1'b1, 1'b1, 1'b0, {N{mk(6'h3f, 26'h1)}}, "R9 reset with input");
    // R1, R2: distinct slots land on their own lanes
    wa = {mk(6'h11, 26'h0333333), mk(6'h22, 26'h0222222),
          mk(6'h33, 26'h0111111), mk(6'h01, 26'h0000abc)};
    step(1'b0, 1'b1, 1'b0, wa, "R1 R2 slot mapping");
    // R3: lanes 1 and 3 empty
    wb = {mk(6'h00, 26'h3ffffff), mk(6'h05, 26'h0000055),
          mk(6'h00, 26'h0000077), mk(6'h3f, 26'h0)};
    step(1'b0, 1'b1, 1'b0, wb, "R3 empty slots");
    // R4: idle word with real opcodes
    step(1'b0, 1'b0, 1'b0, wa, "R4 idle word");
    step(1'b0, 1'b1, 1'b0, wa, "R1 reload");
    // R5, R6: freeze while new words arrive
    step(1'b0, 1'b1, 1'b1, wb, "R5 hold 1");
    step(1'b0, 1'b0, 1'b1, '0, "R5 hold 2");
    wc = {N{mk(6'h2a, 26'h1234567)}};
    step(1'b0, 1'b1, 1'b1, wc, "R5 hold 3");
    // R7: resume takes the word present now
    step(1'b0, 1'b1, 1'b0, wc, "R7 resume");
    // R8: back-to-back dependent words, no stall
    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b1, 1'b0, {N{mk(6'h09, 26'(k))}}, "R8 back to back");
    // R10: reset and freeze together
    step(1'b0, 1'b1, 1'b0, wa, "R1 before clash");
    step(1'b1, 1'b1, 1'b1, wb, "R10 reset over freeze");
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [WW-1:0] w;
      for (int i = 0; i < N; i++) begin
        w[i*W +: W] = $urandom;
        if (($urandom % 3) == 0) w[i*W+26 +: 6] = 6'd0;
      end
      step(1'b0, ($urandom % 4) != 0, ($urandom % 4) == 0, w, "R1 R3 R5 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule